// File: doc/BRIEF.md
# Secure Address Decoder with Error Responder

This block sits on the address/control path of a memory-mapped fabric. For each incoming request it compares the address against a parameter table of address windows. Each window names a target slot (up to 16) and a region number within that target. A target that owns several windows can tell from the region number which window matched.

Each target carries one security bit. A request is forwarded only when its address hits a window and the target it selects accepts that request's security level. The address leaves the block exactly as it arrived.

Two kinds of request are never forwarded: a request that hits no window, and a non-secure request to a secure target. An internal error responder takes such a request and completes it towards the master with a decode-error status.
- For a write, it swallows every data beat up to and including the one flagged last. It then returns one write response.
- For a read, it returns one beat more than the burst-length field. Every beat is marked as a decode error, the final beat carries the last flag, and the request ID is echoed.

Top module: `addr_guard`

## Requirements
- R1: An allowed request drives `fwd_valid` high in the same cycle as `req_valid`, with `fwd_target` and `fwd_region` taken from the matching window and `fwd_addr`, `fwd_id`, `fwd_len`, `fwd_write` equal to the request fields.
- R2: When windows overlap, the window with the lowest table index decides target and region.
- R3: A request to a target whose security bit is 1 is forwarded only when `req_secure` is 1. Otherwise `fwd_valid` stays 0 and the error responder accepts the request with `req_ready` = 1.
- R4: A request whose address matches no window is not forwarded and is accepted by the error responder.
- R5: For a rejected write, `wd_ready` is 1 until the beat with `wd_last` = 1 is taken. The next cycle, one write response is presented with `err_b_resp` = 2'b11 (decode error) and `err_b_id` equal to the request ID. No response is presented before the last beat.
- R6: For a rejected read, exactly `req_len`+1 beats are presented, each with `err_r_resp` = 2'b11 and `err_r_id` equal to the request ID. `err_r_last` is 1 on the final beat only.
- R7: While the error responder is busy, `req_ready` and `fwd_valid` are 0 regardless of the request.
- R8: For an allowed request, `req_ready` equals `fwd_ready`.
- R9: After reset, `err_b_valid`, `err_r_valid` and `wd_ready` are 0.
- R10: A presented error beat or response holds its valid, last and ID values until the handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_addr | input | ADDR_W (32) | Request address |
| req_id | input | ID_W (4) | Transaction ID |
| req_len | input | 8 | Burst length minus one |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure access |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_ready | input | 1 | Forward path ready |
| fwd_addr | output | ADDR_W (32) | Unchanged address |
| fwd_id | output | ID_W (4) | Transaction ID |
| fwd_len | output | 8 | Burst length minus one |
| fwd_write | output | 1 | Direction |
| fwd_target | output | 4 | Selected target slot |
| fwd_region | output | 4 | Matching window's region number |
| wd_valid | input | 1 | Write data beat valid (rejected write) |
| wd_last | input | 1 | Final write data beat |
| wd_ready | output | 1 | Responder takes write data |
| err_b_valid | output | 1 | Error write response valid |
| err_b_ready | input | 1 | Error write response taken |
| err_b_id | output | ID_W (4) | Echoed ID |
| err_b_resp | output | 2 | Response code, 2'b11 |
| err_r_valid | output | 1 | Error read beat valid |
| err_r_ready | input | 1 | Error read beat taken |
| err_r_id | output | ID_W (4) | Echoed ID |
| err_r_resp | output | 2 | Response code, 2'b11 |
| err_r_last | output | 1 | Final read beat |

## Verification
The bench goes after these corner cases, each of which a faulty design would get visibly wrong:
- **Overlapping windows.** The shared address must resolve to the lower-index window. A reversed priority would report region 1 for it.
- **Single-beat read.** A length-zero read must give exactly one beat with last set. An off-by-one beat counter would give two beats, or none with last.
- **Write response timing.** A responder that answers before the last data beat is caught, because the bench watches for a response on every drained beat.
- **Secure target, both ways.** A secure request to the secure target must still go out. A non-secure request to it must not, so a missing or inverted security test shows up as a forward.
- **Busy responder.** A legal request is offered while the responder is busy, so a design that does not lock the request path would forward it.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;
  localparam int TGT_IDX_W = 4;
  localparam int REG_IDX_W = 4;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  typedef enum logic [1:0] {
    ERR_IDLE   = 2'd0,
    ERR_WDRAIN = 2'd1,
    ERR_WRESP  = 2'd2,
    ERR_RDATA  = 2'd3
  } err_state_e;

  // inclusive window test, operands zero-extended by the caller
  function automatic logic in_window(input logic [63:0] a, input logic [63:0] lo,
                                     input logic [63:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // beats still owed after the current one, from the burst-length field
  function automatic logic [7:0] beats_after_first(input logic [7:0] len);
    return len;
  endfunction
endpackage

// File: rtl/ag_range_match.sv
module ag_range_match #(
  parameter int ADDR_W = 32,
  parameter int NUM_WIN = 4,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LO = '0,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HI = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_WIN-1:0] hit
);
  localparam int PAD = 64 - ADDR_W;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hit[w] = addr_guard_pkg::in_window({{PAD{1'b0}}, addr},
                                              {{PAD{1'b0}}, WIN_LO[w]},
                                              {{PAD{1'b0}}, WIN_HI[w]});
  end
endmodule

// File: rtl/ag_decode.sv
module ag_decode
  import addr_guard_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int NUM_TGT = 4,
  parameter logic [NUM_WIN-1:0][TGT_IDX_W-1:0] WIN_TGT = '0,
  parameter logic [NUM_WIN-1:0][REG_IDX_W-1:0] WIN_REG = '0,
  parameter logic [NUM_TGT-1:0] TGT_SECURE = '0
) (
  input  logic [NUM_WIN-1:0]   hit,
  input  logic                 secure,
  output logic                 any_hit,
  output logic                 allowed,
  output logic [TGT_IDX_W-1:0] tgt,
  output logic [REG_IDX_W-1:0] region
);
  logic tgt_sec;

  // walk downwards so that the lowest matching index is written last
  always_comb begin
    tgt = '0;
    region = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit[w]) begin
        tgt = WIN_TGT[w];
        region = WIN_REG[w];
      end
    end
  end

  always_comb begin
    tgt_sec = 1'b0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (tgt == TGT_IDX_W'(t)) tgt_sec = TGT_SECURE[t];
    end
  end

  assign any_hit = |hit;
  assign allowed = any_hit && (!tgt_sec || secure);
endmodule

// File: rtl/ag_err_responder.sv
module ag_err_responder
  import addr_guard_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_wr,
  input  logic            start_rd,
  input  logic [ID_W-1:0] id_in,
  input  logic [7:0]      len_in,
  output logic            busy,
  input  logic            wd_valid,
  input  logic            wd_last,
  output logic            wd_ready,
  output logic            b_valid,
  input  logic            b_ready,
  output logic [ID_W-1:0] b_id,
  output logic            r_valid,
  input  logic            r_ready,
  output logic [ID_W-1:0] r_id,
  output logic            r_last
);
  err_state_e state;
  logic [ID_W-1:0] id_q;
  logic [7:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ERR_IDLE;
      id_q   <= '0;
      left_q <= '0;
    end else begin
      unique case (state)
        ERR_IDLE: begin
          if (start_wr) begin
            state <= ERR_WDRAIN;
            id_q  <= id_in;
          end else if (start_rd) begin
            state  <= ERR_RDATA;
            id_q   <= id_in;
            left_q <= beats_after_first(len_in);
          end
        end
        ERR_WDRAIN: if (wd_valid && wd_last) state <= ERR_WRESP;
        ERR_WRESP:  if (b_ready) state <= ERR_IDLE;
        ERR_RDATA: begin
          if (r_ready) begin
            if (left_q == 8'd0) state <= ERR_IDLE;
            else left_q <= left_q - 8'd1;
          end
        end
        default: state <= ERR_IDLE;
      endcase
    end
  end

  assign busy     = (state != ERR_IDLE);
  assign wd_ready = (state == ERR_WDRAIN);
  assign b_valid  = (state == ERR_WRESP);
  assign r_valid  = (state == ERR_RDATA);
  assign r_last   = r_valid && (left_q == 8'd0);
  assign b_id     = id_q;
  assign r_id     = id_q;
endmodule

// File: rtl/addr_guard.sv
module addr_guard
  import addr_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W = 4,
  parameter int NUM_WIN = 4,
  parameter int NUM_TGT = 4,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LO =
    {32'h8000_0000, 32'h0001_F000, 32'h0001_0000, 32'h0000_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HI =
    {32'h8FFF_FFFF, 32'h0002_0FFF, 32'h0001_FFFF, 32'h0000_FFFF},
  parameter logic [NUM_WIN-1:0][TGT_IDX_W-1:0] WIN_TGT = {4'd2, 4'd1, 4'd1, 4'd0},
  parameter logic [NUM_WIN-1:0][REG_IDX_W-1:0] WIN_REG = {4'd0, 4'd1, 4'd0, 4'd0},
  parameter logic [NUM_TGT-1:0] TGT_SECURE = 4'b0100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [ID_W-1:0]      req_id,
  input  logic [7:0]           req_len,
  input  logic                 req_write,
  input  logic                 req_secure,
  output logic                 fwd_valid,
  input  logic                 fwd_ready,
  output logic [ADDR_W-1:0]    fwd_addr,
  output logic [ID_W-1:0]      fwd_id,
  output logic [7:0]           fwd_len,
  output logic                 fwd_write,
  output logic [TGT_IDX_W-1:0] fwd_target,
  output logic [REG_IDX_W-1:0] fwd_region,
  input  logic                 wd_valid,
  input  logic                 wd_last,
  output logic                 wd_ready,
  output logic                 err_b_valid,
  input  logic                 err_b_ready,
  output logic [ID_W-1:0]      err_b_id,
  output logic [1:0]           err_b_resp,
  output logic                 err_r_valid,
  input  logic                 err_r_ready,
  output logic [ID_W-1:0]      err_r_id,
  output logic [1:0]           err_r_resp,
  output logic                 err_r_last
);
  logic [NUM_WIN-1:0] win_hit;
  logic any_hit, allowed, route_err, err_busy, err_take;

  ag_range_match #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_match (
    .addr(req_addr), .hit(win_hit)
  );

  ag_decode #(
    .NUM_WIN(NUM_WIN), .NUM_TGT(NUM_TGT), .WIN_TGT(WIN_TGT),
    .WIN_REG(WIN_REG), .TGT_SECURE(TGT_SECURE)
  ) u_dec (
    .hit(win_hit), .secure(req_secure), .any_hit(any_hit), .allowed(allowed),
    .tgt(fwd_target), .region(fwd_region)
  );

  assign route_err = !allowed;
  assign fwd_valid = req_valid && !err_busy && !route_err;
  assign req_ready = !err_busy && (route_err || fwd_ready);
  assign err_take  = req_valid && !err_busy && route_err;
  assign fwd_addr  = req_addr;
  assign fwd_id    = req_id;
  assign fwd_len   = req_len;
  assign fwd_write = req_write;

  ag_err_responder #(.ID_W(ID_W)) u_err (
    .clk(clk), .rst_n(rst_n),
    .start_wr(err_take && req_write), .start_rd(err_take && !req_write),
    .id_in(req_id), .len_in(req_len), .busy(err_busy),
    .wd_valid(wd_valid), .wd_last(wd_last), .wd_ready(wd_ready),
    .b_valid(err_b_valid), .b_ready(err_b_ready), .b_id(err_b_id),
    .r_valid(err_r_valid), .r_ready(err_r_ready), .r_id(err_r_id), .r_last(err_r_last)
  );

  assign err_b_resp = RESP_DECERR;
  assign err_r_resp = RESP_DECERR;
endmodule

// File: rtl/addr_guard_chk.sv
module addr_guard_chk #(
  parameter int ID_W = 4,
  parameter int NUM_TGT = 4,
  parameter logic [NUM_TGT-1:0] TGT_SECURE = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_secure,
  input logic            fwd_valid,
  input logic [3:0]      fwd_target,
  input logic            wd_ready,
  input logic            err_b_valid,
  input logic            err_b_ready,
  input logic [1:0]      err_b_resp,
  input logic [ID_W-1:0] err_b_id,
  input logic            err_r_valid,
  input logic            err_r_ready,
  input logic [1:0]      err_r_resp,
  input logic            err_r_last,
  input logic [ID_W-1:0] err_r_id
);
  logic fwd_sec_tgt;

  always_comb begin
    fwd_sec_tgt = 1'b0;
    for (int t = 0; t < NUM_TGT; t++)
      if (fwd_target == 4'(t)) fwd_sec_tgt = TGT_SECURE[t];
  end

  // R3
  secure_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_sec_tgt) |-> req_secure);
  // R5
  wresp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_b_valid |-> (err_b_resp == 2'b11));
  // R5
  wresp_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_b_valid |-> !wd_ready);
  // R6
  rdata_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_r_valid |-> (err_r_resp == 2'b11));
  // R7
  busy_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_r_valid || err_b_valid || wd_ready) |-> !fwd_valid);
  // R10
  rbeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_r_valid && !err_r_ready) |=> (err_r_valid && $stable(err_r_last) && $stable(err_r_id)));
  // R10
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_b_valid && !err_b_ready) |=> (err_b_valid && $stable(err_b_id)));
endmodule

bind addr_guard addr_guard_chk #(
  .ID_W(ID_W), .NUM_TGT(NUM_TGT), .TGT_SECURE(TGT_SECURE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_secure(req_secure), .fwd_valid(fwd_valid),
  .fwd_target(fwd_target), .wd_ready(wd_ready),
  .err_b_valid(err_b_valid), .err_b_ready(err_b_ready), .err_b_resp(err_b_resp),
  .err_b_id(err_b_id), .err_r_valid(err_r_valid), .err_r_ready(err_r_ready),
  .err_r_resp(err_r_resp), .err_r_last(err_r_last), .err_r_id(err_r_id)
);

// File: tb/addr_guard_tb.sv
module addr_guard_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_secure = 0, fwd_ready = 1;
  logic [31:0] req_addr = '0;
  logic [3:0] req_id = '0;
  logic [7:0] req_len = '0;
  logic wd_valid = 0, wd_last = 0, err_b_ready = 0, err_r_ready = 0;
  logic req_ready, fwd_valid, fwd_write, wd_ready, err_b_valid, err_r_valid, err_r_last;
  logic [31:0] fwd_addr;
  logic [3:0] fwd_id, fwd_target, fwd_region, err_b_id, err_r_id;
  logic [7:0] fwd_len;
  logic [1:0] err_b_resp, err_r_resp;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  addr_guard u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_id(req_id), .req_len(req_len), .req_write(req_write),
    .req_secure(req_secure), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_addr(fwd_addr), .fwd_id(fwd_id), .fwd_len(fwd_len), .fwd_write(fwd_write),
    .fwd_target(fwd_target), .fwd_region(fwd_region), .wd_valid(wd_valid),
    .wd_last(wd_last), .wd_ready(wd_ready), .err_b_valid(err_b_valid),
    .err_b_ready(err_b_ready), .err_b_id(err_b_id), .err_b_resp(err_b_resp),
    .err_r_valid(err_r_valid), .err_r_ready(err_r_ready), .err_r_id(err_r_id),
    .err_r_resp(err_r_resp), .err_r_last(err_r_last)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_req(input logic [31:0] a, input logic sec, input logic wr,
                         input logic [3:0] id, input logic [7:0] len);
    req_valid = 1; req_addr = a; req_secure = sec; req_write = wr; req_id = id; req_len = len;
  endtask

  task automatic t_reset();
    check("R9 err_r_valid", err_r_valid, 0);
    check("R9 err_b_valid", err_b_valid, 0);
    check("R9 wd_ready", wd_ready, 0);
  endtask

  task automatic t_fwd(input string tag, input logic [31:0] a, input logic sec,
                       input logic [3:0] et, input logic [3:0] er);
    @(negedge clk);
    put_req(a, sec, 1'b1, 4'h5, 8'd7);
    #1;
    check({tag, " fwd_valid"}, fwd_valid, 1);
    check({tag, " target"}, fwd_target, et);
    check({tag, " region"}, fwd_region, er);
    check("R1 addr unchanged", fwd_addr, a);
    check("R1 id/len/write", {fwd_id, fwd_len, fwd_write}, {4'h5, 8'd7, 1'b1});
    check("R8 ready follows", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_stall();
    @(negedge clk);
    put_req(32'h0000_0100, 1'b0, 1'b0, 4'h1, 8'd0);
    fwd_ready = 0;
    #1;
    check("R8 ready low on stall", req_ready, 0);
    check("R8 fwd_valid held", fwd_valid, 1);
    @(negedge clk);
    fwd_ready = 1; req_valid = 0;
  endtask

  // rejected request is offered; responder takes it at the next edge
  task automatic issue_err(input string tag, input logic [31:0] a, input logic sec,
                           input logic wr, input logic [3:0] id, input logic [7:0] len);
    @(negedge clk);
    put_req(a, sec, wr, id, len);
    #1;
    check({tag, " not forwarded"}, fwd_valid, 0);
    check({tag, " accepted"}, req_ready, 1);
    @(negedge clk);
    put_req(32'h0000_0040, 1'b1, 1'b0, 4'h0, 8'd0);
    #1;
    check("R7 busy blocks ready", req_ready, 0);
    check("R7 busy blocks fwd", fwd_valid, 0);
    req_valid = 0;
  endtask

  task automatic t_err_read(input string tag, input logic [31:0] a, input logic sec,
                            input logic [3:0] id, input logic [7:0] len);
    int beats = 0, bad_last = 0, bad_meta = 0, cyc = 0;
    logic done = 0, prev_stall = 0, prev_last = 0;
    issue_err(tag, a, sec, 1'b0, id, len);
    while (!done && cyc < 600) begin
      err_r_ready = (cyc % 3 != 0);
      #1;
      if (prev_stall) check("R10 read beat held", {err_r_valid, err_r_last}, {1'b1, prev_last});
      prev_stall = err_r_valid && !err_r_ready;
      prev_last = err_r_last;
      if (err_r_valid) begin
        if (err_r_resp != 2'b11 || err_r_id != id) bad_meta++;
        if (err_r_ready) begin
          beats++;
          if (err_r_last != (beats == int'(len) + 1)) bad_last++;
          if (err_r_last) done = 1;
        end
      end
      @(negedge clk);
      cyc++;
    end
    err_r_ready = 0;
    #1;
    check("R6 beat count", beats, int'(len) + 1);
    check("R6 last placement", bad_last, 0);
    check("R6 resp/id", bad_meta, 0);
    check("R6 idle after last", err_r_valid, 0);
  endtask

  task automatic t_err_write(input string tag, input logic [31:0] a, input logic sec,
                             input logic [3:0] id, input int nbeats);
    issue_err(tag, a, sec, 1'b1, id, 8'(nbeats - 1));
    @(negedge clk);
    for (int i = 0; i < nbeats; i++) begin
      wd_valid = 1; wd_last = (i == nbeats - 1);
      #1;
      check("R5 wd_ready during drain", wd_ready, 1);
      check("R5 no early response", err_b_valid, 0);
      @(negedge clk);
    end
    wd_valid = 0; wd_last = 0;
    #1;
    check("R5 response after last", {err_b_valid, err_b_resp, err_b_id}, {1'b1, 2'b11, id});
    check("R5 drain closed", wd_ready, 0);
    @(negedge clk);
    #1;
    check("R10 response held", {err_b_valid, err_b_id}, {1'b1, id});
    err_b_ready = 1;
    @(negedge clk);
    err_b_ready = 0;
    #1;
    check("R5 single response", err_b_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_fwd("R1", 32'h0000_1234, 1'b0, 4'd0, 4'd0);
    t_fwd("R1", 32'h0001_0004, 1'b1, 4'd1, 4'd0);
    t_fwd("R2 overlap", 32'h0001_F800, 1'b0, 4'd1, 4'd0);
    t_fwd("R2 upper", 32'h0002_0800, 1'b0, 4'd1, 4'd1);
    t_fwd("R3 secure ok", 32'h8000_0010, 1'b1, 4'd2, 4'd0);
    t_stall();
    t_err_read("R3 read", 32'h8000_0000, 1'b0, 4'hA, 8'd3);
    t_err_read("R4 read", 32'h4000_0000, 1'b1, 4'h3, 8'd0);
    t_err_write("R4 write", 32'hF000_0000, 1'b0, 4'h7, 3);
    t_err_write("R3 write", 32'h8800_0000, 1'b0, 4'hC, 1);
    t_fwd("R1 after errors", 32'h0000_0008, 1'b0, 4'd0, 4'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule